// File: doc/BRIEF.md
# Descriptor-Chained Memory Copy Channel

This block is one memory-to-memory copy channel. A host programs it through a small 32-bit register window, and the channel then works on its own through linked descriptors held in memory. The host places the address of a descriptor in the channel and sets the run bit. The channel reads the eight-word descriptor: the info word, the source, the destination, the byte length, the stride, the next-descriptor pointer and two spare words. It then copies whole 32-bit words from source to destination, one read followed by one write. When a descriptor is finished, the channel moves to the next one unless the next pointer is zero.

The memory port is a single word-wide request/ready channel. A beat completes in any cycle where both request and ready are high. The host can pause and resume the channel, abort the current descriptor, or wipe the whole channel back to its reset state. Done, interrupt and error indications are cleared by writing ones. The stride, width, peripheral-pacing and 2D fields are kept in the descriptor mirrors, but the channel does not act on them.

Top module: `dma_desc_channel`

## Requirements
- R1: After reset every register reads zero, the channel is idle, no memory request is raised and `irq` is low.
- R2: Writing the control word (offset 0x00) with bit 0 set while idle makes the channel read eight words in ascending order from the descriptor address (offset 0x04). The loaded info, source, destination, length, stride and next words are then readable at offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C.
- R3: A descriptor copies floor(length/4) words, each read from the source address and then written to the destination address. Info bit 8 makes the source advance by 4 after each word, and info bit 4 does the same for the destination. With a bit clear, that address stays fixed. The source and destination mirrors show the advanced addresses.
- R4: At the end of a descriptor whose next pointer is zero, the control word shows bit 1 (done) set and bit 0 (active) clear. A nonzero next pointer makes the channel fetch and run that descriptor with no host action.
- R5: Control bit 2 (interrupt) is set at the end of a descriptor only when info bit 0 is set. Output `irq` is high while control bit 2 or control bit 8 is set. Writing 1 to control bit 1 or bit 2 clears that bit only.
- R6: A length below 4 finishes the descriptor after its eight descriptor reads, with no data read and no data write.
- R7: Writing the control word with bit 0 clear while active holds off all memory requests, and control bit 4 (paused) reads 1. Writing bit 0 set resumes the copy from where it stopped.
- R8: Writing control bit 30 while active ends the current descriptor without setting done or interrupt. The channel goes idle if the next pointer is zero, and otherwise runs the next descriptor.
- R9: Writing control bit 31 makes the channel idle and clears every register, including the descriptor address and all flags.
- R10: A descriptor address with any of its low 5 bits set, whether written by the host or taken from a next pointer, stops the channel without a fetch. It also sets debug bit 0 (offset 0x20), which makes control bit 8 read 1 and raises `irq`. Writing 1 to a debug bit in bits 2:0 clears it.
- R11: Writes to the descriptor address register while the channel is active have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWe | input | 1 | Register write strobe |
| hostAddr | input | 6 | Register byte offset |
| hostWdata | input | 32 | Register write data |
| hostRdata | output | 32 | Register read data for `hostAddr` (combinational) |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | Beat is a write when high |
| memAddr | output | 32 | Byte address of the beat |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with `memReady` |
| memReady | input | 1 | Memory accepts the beat this cycle |
| irq | output | 1 | Interrupt: done-interrupt or error pending |

## Verification
The bench uses the default package values: 32-bit words, eight-word descriptors aligned to 32 bytes, and a 6-bit register window. With these values a full descriptor chain, a 16-word copy and every register mirror fit in a 1 KiB bench memory. The memory model can add a wait cycle to every other beat, so each transfer pattern runs both with ready held high and with back-pressure. Because a long copy takes more cycles than the eight-cycle descriptor fetch, the bench can land a pause or an abort reliably, both in the fetch phase and part-way through the data phase.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int WORD_W     = 32;
  localparam int HOST_AW    = 6;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int ALIGN_W    = $clog2(DESC_WORDS * 4);
  localparam int CNT_W      = WORD_W - 2;
  localparam int ERR_W      = 3;

  localparam logic [HOST_AW-1:0] OFF_CS     = 6'h00;
  localparam logic [HOST_AW-1:0] OFF_CB     = 6'h04;
  localparam logic [HOST_AW-1:0] OFF_INFO   = 6'h08;
  localparam logic [HOST_AW-1:0] OFF_SRC    = 6'h0C;
  localparam logic [HOST_AW-1:0] OFF_DST    = 6'h10;
  localparam logic [HOST_AW-1:0] OFF_LEN    = 6'h14;
  localparam logic [HOST_AW-1:0] OFF_STRIDE = 6'h18;
  localparam logic [HOST_AW-1:0] OFF_NEXT   = 6'h1C;
  localparam logic [HOST_AW-1:0] OFF_DBG    = 6'h20;

  localparam int CS_RUN   = 0;
  localparam int CS_DONE  = 1;
  localparam int CS_IRQ   = 2;
  localparam int CS_PAUSE = 4;
  localparam int CS_ERR   = 8;
  localparam int CS_ABORT = 30;
  localparam int CS_WIPE  = 31;

  localparam int INFO_IRQ_EN  = 0;
  localparam int INFO_DST_INC = 4;
  localparam int INFO_SRC_INC = 8;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_READ, ST_WRITE, ST_FINISH} chanState_t;
  typedef enum logic [1:0] {SEL_DESC, SEL_SRC, SEL_DST} addrSel_t;

  typedef struct packed {
    addrSel_t         addrSel;
    logic [IDX_W-1:0] fetchIdx;
    logic             fetchWord;
    logic             readBeat;
    logic             writeBeat;
    logic             chainNext;
    logic             markEnd;
    logic             markIrq;
    logic             markAlignErr;
    logic             wipe;
  } dpCmd_t;

  typedef struct packed {
    logic wordsZero;
    logic lastWord;
    logic nextNull;
    logic nextAligned;
    logic cbAligned;
    logic irqEnable;
  } dpStat_t;
endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    csWrite,
  input  logic    csRun,
  input  logic    csAbort,
  input  logic    csWipe,
  input  dpStat_t stat,
  input  logic    memReady,
  output logic    memReq,
  output logic    memWe,
  output logic    chanActive,
  output logic    chanPaused,
  output dpCmd_t  cmd
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  chanState_t       state, stateNxt;
  logic [IDX_W-1:0] idx, idxNxt;
  logic             paused, pausedNxt;
  logic             beat;

  assign chanActive = (state != ST_IDLE);
  assign chanPaused = paused;
  assign memReq = !paused && (state == ST_FETCH || state == ST_READ || state == ST_WRITE);
  assign memWe  = (state == ST_WRITE);
  assign beat   = memReq && memReady;

  always_comb begin
    stateNxt = state;
    idxNxt = idx;
    pausedNxt = paused;
    cmd = '0;
    cmd.fetchIdx = idx;
    cmd.addrSel = (state == ST_READ) ? SEL_SRC : (state == ST_WRITE) ? SEL_DST : SEL_DESC;
    if (csWrite && csWipe) begin
      cmd.wipe = 1'b1;
      stateNxt = ST_IDLE;
      idxNxt = '0;
      pausedNxt = 1'b0;
    end else if (csWrite && csAbort && chanActive) begin
      pausedNxt = 1'b0;
      idxNxt = '0;
      if (stat.nextNull) begin
        stateNxt = ST_IDLE;
      end else if (!stat.nextAligned) begin
        cmd.markAlignErr = 1'b1;
        stateNxt = ST_IDLE;
      end else begin
        cmd.chainNext = 1'b1;
        stateNxt = ST_FETCH;
      end
    end else begin
      if (csWrite && chanActive) pausedNxt = !csRun;
      unique case (state)
        ST_IDLE: begin
          if (csWrite && csRun) begin
            if (stat.cbAligned) begin
              stateNxt = ST_FETCH;
              idxNxt = '0;
            end else begin
              cmd.markAlignErr = 1'b1;
            end
          end
        end
        ST_FETCH: begin
          if (beat) begin
            cmd.fetchWord = 1'b1;
            if (idx == LAST_IDX) begin
              idxNxt = '0;
              stateNxt = stat.wordsZero ? ST_FINISH : ST_READ;
            end else begin
              idxNxt = idx + 1'b1;
            end
          end
        end
        ST_READ: begin
          if (beat) begin
            cmd.readBeat = 1'b1;
            stateNxt = ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (beat) begin
            cmd.writeBeat = 1'b1;
            stateNxt = stat.lastWord ? ST_FINISH : ST_READ;
          end
        end
        ST_FINISH: begin
          cmd.markIrq = stat.irqEnable;
          if (stat.nextNull) begin
            cmd.markEnd = 1'b1;
            stateNxt = ST_IDLE;
            pausedNxt = 1'b0;
          end else if (!stat.nextAligned) begin
            cmd.markAlignErr = 1'b1;
            stateNxt = ST_IDLE;
            pausedNxt = 1'b0;
          end else begin
            cmd.chainNext = 1'b1;
            stateNxt = ST_FETCH;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx <= '0;
      paused <= 1'b0;
    end else begin
      state <= stateNxt;
      idx <= idxNxt;
      paused <= pausedNxt;
    end
  end

  // R9: a wipe leaves the channel idle and silent
  p_wipe_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    csWrite && csWipe |=> !chanActive && !memReq);

  // R7: a pause write stops the memory port from the next cycle
  p_pause_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    csWrite && !csRun && !csAbort && !csWipe && chanActive |=> !memReq);

  // R10: a misaligned start never becomes active
  p_misaligned_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    csWrite && csRun && !csWipe && !chanActive && !stat.cbAligned |=> !chanActive);

  // R8: abort with a null next pointer ends in idle
  p_abort_null_r8: assert property (@(posedge clk) disable iff (!rstN)
    csWrite && csAbort && !csWipe && chanActive && stat.nextNull |=> !chanActive);
endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [WORD_W-1:0]  hostWdata,
  output logic [WORD_W-1:0]  hostRdata,
  input  dpCmd_t             cmd,
  input  logic               chanActive,
  input  logic               chanPaused,
  output dpStat_t            stat,
  output logic [WORD_W-1:0]  memAddr,
  output logic [WORD_W-1:0]  memWdata,
  input  logic [WORD_W-1:0]  memRdata,
  output logic               irq
);
  logic [WORD_W-1:0] cbAddr, info, srcAddr, dstAddr, lenBytes, stride, nextCb, dataBuf;
  logic [CNT_W-1:0]  wordsLeft;
  logic [ERR_W-1:0]  errFlags;
  logic              doneFlag, irqFlag;
  logic              csWr, dbgWr;
  logic [WORD_W-1:0] csView;

  assign csWr  = hostWe && (hostAddr == OFF_CS);
  assign dbgWr = hostWe && (hostAddr == OFF_DBG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cbAddr <= '0; info <= '0; srcAddr <= '0; dstAddr <= '0;
      lenBytes <= '0; stride <= '0; nextCb <= '0; dataBuf <= '0;
      wordsLeft <= '0; errFlags <= '0; doneFlag <= 1'b0; irqFlag <= 1'b0;
    end else if (cmd.wipe) begin
      cbAddr <= '0; info <= '0; srcAddr <= '0; dstAddr <= '0;
      lenBytes <= '0; stride <= '0; nextCb <= '0; dataBuf <= '0;
      wordsLeft <= '0; errFlags <= '0; doneFlag <= 1'b0; irqFlag <= 1'b0;
    end else begin
      if (hostWe && hostAddr == OFF_CB && !chanActive) cbAddr <= hostWdata;
      if (cmd.chainNext) cbAddr <= nextCb;
      if (cmd.fetchWord) begin
        case (int'(cmd.fetchIdx))
          0: info <= memRdata;
          1: srcAddr <= memRdata;
          2: dstAddr <= memRdata;
          3: begin
            lenBytes <= memRdata;
            wordsLeft <= memRdata[WORD_W-1:2];
          end
          4: stride <= memRdata;
          5: nextCb <= memRdata;
          default: ;
        endcase
      end
      if (cmd.readBeat) dataBuf <= memRdata;
      if (cmd.writeBeat) begin
        if (info[INFO_SRC_INC]) srcAddr <= srcAddr + 32'd4;
        if (info[INFO_DST_INC]) dstAddr <= dstAddr + 32'd4;
        wordsLeft <= wordsLeft - 1'b1;
      end
      if (csWr && hostWdata[CS_DONE]) doneFlag <= 1'b0;
      if (csWr && hostWdata[CS_IRQ]) irqFlag <= 1'b0;
      if (cmd.markEnd) doneFlag <= 1'b1;
      if (cmd.markIrq) irqFlag <= 1'b1;
      if (dbgWr) errFlags <= errFlags & ~hostWdata[ERR_W-1:0];
      if (cmd.markAlignErr) errFlags[0] <= 1'b1;
    end
  end

  always_comb begin
    unique case (cmd.addrSel)
      SEL_SRC: memAddr = srcAddr;
      SEL_DST: memAddr = dstAddr;
      default: memAddr = cbAddr + WORD_W'({cmd.fetchIdx, 2'b00});
    endcase
  end
  assign memWdata = dataBuf;

  assign stat.wordsZero   = (wordsLeft == '0);
  assign stat.lastWord    = (wordsLeft == CNT_W'(1));
  assign stat.nextNull    = (nextCb == '0);
  assign stat.nextAligned = (nextCb[ALIGN_W-1:0] == '0);
  assign stat.cbAligned   = (cbAddr[ALIGN_W-1:0] == '0);
  assign stat.irqEnable   = info[INFO_IRQ_EN];

  assign irq = irqFlag || (|errFlags);

  always_comb begin
    csView = '0;
    csView[CS_RUN]   = chanActive;
    csView[CS_DONE]  = doneFlag;
    csView[CS_IRQ]   = irqFlag;
    csView[CS_PAUSE] = chanPaused;
    csView[CS_ERR]   = |errFlags;
    unique case (hostAddr)
      OFF_CS:     hostRdata = csView;
      OFF_CB:     hostRdata = cbAddr;
      OFF_INFO:   hostRdata = info;
      OFF_SRC:    hostRdata = srcAddr;
      OFF_DST:    hostRdata = dstAddr;
      OFF_LEN:    hostRdata = lenBytes;
      OFF_STRIDE: hostRdata = stride;
      OFF_NEXT:   hostRdata = nextCb;
      OFF_DBG:    hostRdata = WORD_W'(errFlags);
      default:    hostRdata = '0;
    endcase
  end

  // R4: done only rises together with the channel falling idle
  p_done_when_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> !chanActive);

  // R10: write-one-to-clear of debug bit 0 when no new error arrives
  p_dbg_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    dbgWr && hostWdata[0] && !cmd.markAlignErr && !cmd.wipe |=> !errFlags[0]);

  // R11: descriptor address holds while busy unless chaining or wiping
  p_cb_locked_r11: assert property (@(posedge clk) disable iff (!rstN)
    chanActive && !cmd.chainNext && !cmd.wipe |=> $stable(cbAddr));
endmodule

// File: rtl/dma_desc_channel.sv
module dma_desc_channel
  import dma_chan_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [WORD_W-1:0]  hostWdata,
  output logic [WORD_W-1:0]  hostRdata,
  output logic               memReq,
  output logic               memWe,
  output logic [WORD_W-1:0]  memAddr,
  output logic [WORD_W-1:0]  memWdata,
  input  logic [WORD_W-1:0]  memRdata,
  input  logic               memReady,
  output logic               irq
);
  dpCmd_t  cmd;
  dpStat_t stat;
  logic    chanActive, chanPaused, csWrite;

  assign csWrite = hostWe && (hostAddr == OFF_CS);

  dma_chan_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .csWrite(csWrite), .csRun(hostWdata[CS_RUN]),
    .csAbort(hostWdata[CS_ABORT]), .csWipe(hostWdata[CS_WIPE]),
    .stat(stat), .memReady(memReady),
    .memReq(memReq), .memWe(memWe),
    .chanActive(chanActive), .chanPaused(chanPaused), .cmd(cmd)
  );

  dma_chan_dp dp_i (
    .clk(clk), .rstN(rstN),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .cmd(cmd), .chanActive(chanActive), .chanPaused(chanPaused), .stat(stat),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .irq(irq)
  );
endmodule

// File: tb/dma_desc_channel_tb_top.sv
module dma_desc_channel_tb_top;
  import dma_chan_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [5:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        memReq, memWe, memReady, irq;
  logic [31:0] memAddr, memWdata, memRdata;

  logic [31:0] mem [256];
  logic stallMode = 1'b0;
  logic phase = 1'b0;
  int beatCnt = 0, wrCnt = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  dma_desc_channel dut_i (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady), .irq(irq)
  );

  assign memReady = memReq && (!stallMode || phase);
  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk) begin
    phase <= ~phase;
    if (memReq && memReady) begin
      beatCnt <= beatCnt + 1;
      if (memWe) begin
        wrCnt <= wrCnt + 1;
        mem[memAddr[9:2]] <= memWdata;
      end
    end
  end

  typedef struct packed {
    logic [7:0] len;
    logic       sInc;
    logic       dInc;
    logic       iEn;
    logic       stall;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{8'd16, 1'b1, 1'b1, 1'b1, 1'b0},
    '{8'd22, 1'b1, 1'b1, 1'b0, 1'b1},
    '{8'd12, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'd12, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  function automatic logic [31:0] pat(int i);
    return 32'hC0DE_0000 + i * 32'h0101;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] cs;
    for (int n = 0; n < 3000; n++) begin
      rd(OFF_CS, cs);
      if (!cs[0]) break;
    end
  endtask

  task automatic putDesc(int w, logic [31:0] inf, logic [31:0] s, logic [31:0] d,
                         logic [31:0] l, logic [31:0] nx);
    mem[w] <= inf; mem[w+1] <= s; mem[w+2] <= d; mem[w+3] <= l;
    mem[w+4] <= 32'h55; mem[w+5] <= nx; mem[w+6] <= 32'hDEAD; mem[w+7] <= 32'hBEEF;
  endtask

  task automatic fill();
    for (int i = 0; i < 16; i++) begin
      mem[64+i] <= pat(i);
      mem[128+i] <= '0;
      mem[160+i] <= '0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, exp [16];
    int b0, w0, words, bad;
    for (int i = 0; i < 256; i++) mem[i] <= '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    rd(OFF_CS, r);  chk("R1 cs", r, 32'h0);
    rd(OFF_CB, r);  chk("R1 cb", r, 32'h0);
    rd(OFF_LEN, r); chk("R1 len", r, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 memReq", {31'b0, memReq}, 32'h0);

    // R2 R3 R4 R5: table of transfer patterns
    for (int v = 0; v < 4; v++) begin
      fill();
      putDesc(0, (32'(VECS[v].sInc) << 8) | (32'(VECS[v].dInc) << 4) | 32'(VECS[v].iEn),
              32'h100, 32'h200, 32'(VECS[v].len), 32'h0);
      stallMode = VECS[v].stall;
      wr(OFF_CS, 32'h6);
      wr(OFF_CB, 32'h0);
      wr(OFF_CS, 32'h1);
      waitIdle();
      words = int'(VECS[v].len) / 4;
      for (int i = 0; i < 16; i++) exp[i] = '0;
      for (int k = 0; k < words; k++) exp[VECS[v].dInc ? k : 0] = pat(VECS[v].sInc ? k : 0);
      bad = 0;
      for (int i = 0; i < 16; i++) if (mem[128+i] !== exp[i]) bad++;
      chk("R3 copied data mismatches", 32'(bad), 32'h0);
      rd(OFF_SRC, r); chk("R3 src mirror", r, 32'h100 + (VECS[v].sInc ? 32'(4*words) : 0));
      rd(OFF_DST, r); chk("R3 dst mirror", r, 32'h200 + (VECS[v].dInc ? 32'(4*words) : 0));
      rd(OFF_LEN, r); chk("R2 len mirror", r, 32'(VECS[v].len));
      rd(OFF_STRIDE, r); chk("R2 stride mirror", r, 32'h55);
      rd(OFF_CS, r);
      chk("R4 done set active clear", r & 32'h3, 32'h2);
      chk("R5 int follows enable", (r >> 2) & 32'h1, 32'(VECS[v].iEn));
      chk("R5 irq pin", {31'b0, irq}, 32'(VECS[v].iEn));
    end
    stallMode = 1'b0;

    // R6: zero length
    putDesc(0, 32'h111, 32'h100, 32'h200, 32'h3, 32'h0);
    wr(OFF_CS, 32'h6);
    b0 = beatCnt; w0 = wrCnt;
    wr(OFF_CS, 32'h1);
    waitIdle();
    chk("R6 beats", 32'(beatCnt - b0), 32'd8);
    chk("R6 writes", 32'(wrCnt - w0), 32'd0);
    rd(OFF_CS, r); chk("R6 done+int", r & 32'h7, 32'h6);

    // R4: chain of two descriptors
    fill();
    putDesc(0, 32'h110, 32'h100, 32'h200, 32'd8, 32'h20);
    putDesc(8, 32'h111, 32'h110, 32'h280, 32'd12, 32'h0);
    wr(OFF_CS, 32'h6);
    b0 = beatCnt;
    wr(OFF_CS, 32'h1);
    waitIdle();
    chk("R4 chain beats", 32'(beatCnt - b0), 32'd26);
    chk("R4 chain first", mem[129], pat(1));
    chk("R4 chain second", mem[162], pat(6));
    rd(OFF_CB, r); chk("R4 cb follows chain", r, 32'h20);
    rd(OFF_CS, r); chk("R4 chain done", r & 32'h7, 32'h6);

    // R5: write-one-to-clear
    wr(OFF_CS, 32'h4);
    rd(OFF_CS, r); chk("R5 int cleared end kept", r & 32'h7, 32'h2);
    chk("R5 irq low", {31'b0, irq}, 32'h0);
    wr(OFF_CS, 32'h2);
    rd(OFF_CS, r); chk("R5 end cleared", r & 32'h7, 32'h0);

    // R7 R11: pause, locked address, resume
    fill();
    wr(OFF_CB, 32'h0);
    putDesc(0, 32'h110, 32'h100, 32'h200, 32'd64, 32'h0);
    wr(OFF_CS, 32'h1);
    wr(OFF_CS, 32'h0);
    b0 = beatCnt;
    repeat (20) @(posedge clk);
    chk("R7 no beats while paused", 32'(beatCnt - b0), 32'd0);
    rd(OFF_CS, r); chk("R7 paused active", r & 32'h11, 32'h11);
    wr(OFF_CB, 32'h40);
    rd(OFF_CB, r); chk("R11 cb write ignored", r, 32'h0);
    wr(OFF_CS, 32'h1);
    waitIdle();
    chk("R7 resumed copy", mem[143], pat(15));
    rd(OFF_CS, r); chk("R7 done after resume", r & 32'h13, 32'h2);

    // R8: abort with null next
    wr(OFF_CS, 32'h8000_0000);
    fill();
    putDesc(0, 32'h110, 32'h100, 32'h200, 32'd64, 32'h0);
    wr(OFF_CS, 32'h1);
    repeat (12) @(posedge clk);
    wr(OFF_CS, 32'h4000_0000);
    rd(OFF_CS, r); chk("R8 abort idle no done", r & 32'h7, 32'h0);
    chk("R8 abort stopped copy", mem[143], 32'h0);

    // R8: abort with chained next
    fill();
    putDesc(0, 32'h110, 32'h100, 32'h200, 32'd64, 32'h20);
    putDesc(8, 32'h110, 32'h100, 32'h280, 32'd8, 32'h0);
    wr(OFF_CS, 32'h1);
    repeat (12) @(posedge clk);
    wr(OFF_CS, 32'h4000_0001);
    waitIdle();
    chk("R8 abort chained copy", mem[161], pat(1));
    chk("R8 abort first cut", mem[143], 32'h0);
    rd(OFF_CS, r); chk("R8 chained done", r & 32'h3, 32'h2);

    // R9: wipe
    wr(OFF_CS, 32'h8000_0000);
    rd(OFF_CB, r);   chk("R9 cb wiped", r, 32'h0);
    rd(OFF_INFO, r); chk("R9 info wiped", r, 32'h0);
    rd(OFF_NEXT, r); chk("R9 next wiped", r, 32'h0);
    rd(OFF_CS, r);   chk("R9 cs wiped", r, 32'h0);

    // R10: misaligned descriptor address
    wr(OFF_CB, 32'h24);
    b0 = beatCnt;
    wr(OFF_CS, 32'h1);
    repeat (3) @(posedge clk);
    rd(OFF_CS, r);  chk("R10 idle with error", r & 32'h101, 32'h100);
    rd(OFF_DBG, r); chk("R10 debug flag", r, 32'h1);
    chk("R10 irq", {31'b0, irq}, 32'h1);
    chk("R10 no fetch", 32'(beatCnt - b0), 32'd0);
    wr(OFF_DBG, 32'h1);
    rd(OFF_DBG, r); chk("R10 debug cleared", r, 32'h0);
    rd(OFF_CS, r);  chk("R10 error cleared", r & 32'h100, 32'h0);
    chk("R10 irq low", {31'b0, irq}, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule